// File: doc/BRIEF.md
# Two-Section CIC Decimator for a One-Bit Modulator Stream

This block turns the single-bit output of an oversampling sigma-delta modulator into a wide signed sample. It applies a fourth-order cascaded integrator-comb response that decimates by 320. The work is split between two fourth-order sections. The fast section reduces the rate by 5 and the slow section reduces it by a further 64. Each input bit counts as +1 when high and −1 when low. At a 19.2 kHz bit rate the block delivers 60 words per second.

The fast section is written in polyphase form. Only a four-bit shift register and a modulo-5 phase counter run on the input clock. The 17-tap box-convolution kernel is evaluated once per group of five bits, on a clock that is gated open for that single edge. The slow integrators run on the same clock. The slow combs and the output register run on a second gated clock that opens once every 320 input cycles. None of the reduced-rate registers uses a data enable.

Top module: `cic2_decim`

## Requirements
- R1: At each output strobe, `dataOut` equals the fourth-order cascade of length-320 moving sums over the bipolar input, where bit 1 counts as +1 and bit 0 counts as −1. The window ends with the bit sampled on the clock edge just before the strobe cycle.
- R2: After reset is released, the first input edge samples bit 0. `outValid` is high during the cycle that follows the edge sampling bit 319. It then rises every 320 cycles and stays high for exactly one cycle.
- R3: Between strobes `dataOut` keeps the last value produced and does not change.
- R4: After enough constant input has passed, `dataOut` settles to exactly +10485760000 (320^4) for a run of ones and to −10485760000 for a run of zeros.
- R5: After reset, the fast section treats all earlier input as zero bits (value −1). The slow section starts from an all-zero state. The first output is therefore a partial sum under this convention.
- R6: Reset is synchronous. After a clock edge with reset high, `outValid` is 0 and `dataOut` is 0. A reset in mid-stream restarts the 320-cycle output phase.
- R7: `dataOut` is a 35-bit two's-complement word. At a strobe its magnitude never exceeds 320^4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input bit clock (oversampling rate) |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Modulator bit, 1 for +1 and 0 for −1 |
| dataOut | output | 35 | Decimated signed sample, held between strobes |
| outValid | output | 1 | One-cycle strobe marking a new `dataOut` |

## Verification
The hardest state to reach from the ports is the start-up transient. In that state the fast section is still weighting pre-reset history as −1 while the slow combs have not yet filled their 64-sample windows. A wrong history convention or an off-by-one frame alignment shows up only in the first few outputs after a reset. The stimulus therefore resets before every pattern and checks each output against an independent moving-sum model from the first strobe. A reset issued partway through a frame then makes the 320-cycle phase restart somewhere other than a frame boundary. Long runs of constant ones and zeros push the output to its full-scale extremes of ±320^4.

// File: rtl/cic2_pkg.sv
package cic2_pkg;
  // Gate-open requests from the control to the two clock gates
  typedef struct packed {
    logic frameOpen; // once per R1 input bits (and during reset)
    logic outOpen;   // once per R1*R2 input bits (and during reset)
  } cic2_strobe_t;
endpackage

// File: rtl/cic2_clkgate.sv
module cic2_clkgate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic enHeld;

  // enable captured while the clock is low, so the AND cannot glitch
  always_latch begin
    if (!clk) enHeld <= en;
  end

  assign gclk = clk & enHeld;
endmodule

// File: rtl/cic2_ctrl.sv
module cic2_ctrl
  import cic2_pkg::*;
#(
  parameter int R1 = 5,
  parameter int R2 = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frameClk,
  output cic2_strobe_t strobe,
  output logic         outValid
);
  localparam int PW = (R1 > 1) ? $clog2(R1) : 1;
  localparam int FW = (R2 > 1) ? $clog2(R2) : 1;

  logic [PW-1:0] phase;
  logic [FW-1:0] frame;
  logic          frameDone;
  logic          outDone;

  assign frameDone = (phase == PW'(R1 - 1));
  assign outDone   = frameDone && (frame == FW'(R2 - 1));

  // full-rate phase counter: the only control logic at the input rate
  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (frameDone) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  // frame counter lives on the gated frame clock
  always_ff @(posedge frameClk) begin
    if (rst)                          frame <= '0;
    else if (frame == FW'(R2 - 1))    frame <= '0;
    else                              frame <= frame + 1'b1;
  end

  always_comb begin
    strobe.frameOpen = rst | frameDone;
    strobe.outOpen   = rst | outDone;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= outDone;
  end
endmodule

// File: rtl/cic2_datapath.sv
module cic2_datapath #(
  parameter int R1    = 5,
  parameter int R2    = 64,
  parameter int ORDER = 4,
  parameter int W1    = 11,
  parameter int OUT_W = 35
) (
  input  logic                    clk,
  input  logic                    frameClk,
  input  logic                    outClk,
  input  logic                    rst,
  input  logic                    bitIn,
  output logic signed [OUT_W-1:0] dataOut
);
  localparam int TAPS = ORDER * (R1 - 1) + 1;
  localparam int HIST = TAPS - R1;
  localparam int FULL = R1 ** ORDER;
  localparam int ACCW = W1 + 1;

  // weight of tap idx in the ORDER-fold self-convolution of a length-R1 box
  function automatic int tapWeight(input int idx);
    int cur [TAPS];
    int nxt [TAPS];
    for (int i = 0; i < TAPS; i++) cur[i] = (i == 0) ? 1 : 0;
    for (int s = 0; s < ORDER; s++) begin
      for (int i = 0; i < TAPS; i++) begin
        nxt[i] = 0;
        for (int k = 0; k < R1; k++)
          if (i - k >= 0) nxt[i] = nxt[i] + cur[i - k];
      end
      for (int i = 0; i < TAPS; i++) cur[i] = nxt[i];
    end
    return cur[idx];
  endfunction

  // ---- fast section: polyphase form, only this shift register at full rate
  logic [R1-2:0]   recent;
  logic [HIST-1:0] hist;
  logic [TAPS-1:0] window;

  always_ff @(posedge clk) begin
    if (rst) recent <= '0;
    else     recent <= (R1 - 1)'({recent, bitIn});
  end

  assign window = {hist, recent, bitIn};

  always_ff @(posedge frameClk) begin
    if (rst) hist <= '0;
    else     hist <= window[HIST-1:0];
  end

  logic [ACCW-1:0] tapTerm [TAPS];
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int WEIGHT = tapWeight(t);
    assign tapTerm[t] = window[t] ? ACCW'(WEIGHT) : '0;
  end

  logic [ACCW-1:0]        onesWeight;
  logic signed [ACCW+1:0] twice;
  logic signed [W1-1:0]   fastOut;

  always_comb begin
    onesWeight = '0;
    for (int t = 0; t < TAPS; t++) onesWeight = onesWeight + tapTerm[t];
  end

  // bipolar sum = 2*(weight of ones) - total weight
  assign twice   = $signed({1'b0, onesWeight, 1'b0}) - $signed((ACCW + 2)'(FULL));
  assign fastOut = W1'(twice);

  // ---- slow section integrators on the frame clock
  logic signed [OUT_W-1:0] integNext [ORDER];
  for (genvar k = 0; k < ORDER; k++) begin : g_int
    logic signed [OUT_W-1:0] acc;
    if (k == 0) begin : g_head
      assign integNext[k] = acc + OUT_W'(fastOut);
    end else begin : g_chain
      assign integNext[k] = acc + integNext[k-1];
    end
    always_ff @(posedge frameClk) begin
      if (rst) acc <= '0;
      else     acc <= integNext[k];
    end
  end

  // ---- slow section combs on the output clock
  logic signed [OUT_W-1:0] combStage [ORDER+1];
  assign combStage[0] = integNext[ORDER-1];
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    logic signed [OUT_W-1:0] dly;
    assign combStage[k+1] = combStage[k] - dly;
    always_ff @(posedge outClk) begin
      if (rst) dly <= '0;
      else     dly <= combStage[k];
    end
  end

  always_ff @(posedge outClk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= combStage[ORDER];
  end
endmodule

// File: rtl/cic2_decim.sv
module cic2_decim
  import cic2_pkg::*;
#(
  parameter  int R1    = 5,
  parameter  int R2    = 64,
  parameter  int ORDER = 4,
  localparam int W1    = $clog2(R1 ** ORDER + 1) + 1,
  localparam int OUT_W = W1 + ORDER * $clog2(R2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bitIn,
  output logic signed [OUT_W-1:0] dataOut,
  output logic                    outValid
);
  cic2_strobe_t strobe;
  logic [1:0]   gateEn;
  logic [1:0]   gclk;

  assign gateEn = {strobe.outOpen, strobe.frameOpen};

  for (genvar g = 0; g < 2; g++) begin : g_gate
    cic2_clkgate u_gate (.clk(clk), .en(gateEn[g]), .gclk(gclk[g]));
  end

  cic2_ctrl #(.R1(R1), .R2(R2)) u_ctrl (
    .clk(clk), .rst(rst), .frameClk(gclk[0]),
    .strobe(strobe), .outValid(outValid)
  );

  cic2_datapath #(.R1(R1), .R2(R2), .ORDER(ORDER), .W1(W1), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .frameClk(gclk[0]), .outClk(gclk[1]), .rst(rst),
    .bitIn(bitIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/cic2_checker.sv
module cic2_checker #(
  parameter int TOTAL = 320,
  parameter int ORDER = 4,
  parameter int OUT_W = 35
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] dataOut
);
  function automatic longint powL(input int base, input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * base;
    return r;
  endfunction

  localparam longint BOUND = powL(TOTAL, ORDER);

  logic [31:0] gap;
  always_ff @(posedge clk) begin
    if (rst)           gap <= '0;
    else if (outValid) gap <= 32'd1;
    else               gap <= gap + 32'd1;
  end

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  p_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (gap == 32'(TOTAL)));

  p_due_r2: assert property (@(posedge clk) disable iff (rst)
    (gap == 32'(TOTAL)) |-> outValid);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(dataOut));

  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> (!outValid && dataOut == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (longint'(dataOut) <= BOUND && longint'(dataOut) >= -BOUND));
endmodule

bind cic2_decim cic2_checker #(.TOTAL(R1 * R2), .ORDER(ORDER), .OUT_W(OUT_W)) u_cic2_checker (
  .clk(clk), .rst(rst), .outValid(outValid), .dataOut(dataOut)
);

// File: tb/cic2_decim_bench.sv
`timescale 1ns/1ps
module cic2_decim_bench;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bitIn = 1'b0;
  logic signed [34:0] dataOut;
  logic               outValid;

  cic2_decim u_cic2_decim (
    .clk(clk), .rst(rst), .bitIn(bitIn), .dataOut(dataOut), .outValid(outValid)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  localparam longint FULLSCALE = 64'd10485760000;

  // {mode[3:0], seed[15:0], outputs[7:0]}; mode 0 ones,1 zeros,2 alternating,3 prbs,4 one-in-three
  localparam logic [27:0] PLAN [6] = '{
    {4'd0, 16'h0000, 8'd6},
    {4'd1, 16'h0000, 8'd6},
    {4'd2, 16'h0000, 8'd5},
    {4'd3, 16'hACE1, 8'd6},
    {4'd3, 16'h1D2B, 8'd5},
    {4'd4, 16'h0000, 8'd5}
  };

  // independent model: cascaded moving sums
  longint fq [4][5];
  longint sq [4][64];
  int     bitCount, frameCount, outCount;
  longint held;
  bit     expValid;
  logic [15:0] lfsr;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    longint sc = 1;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 5; i++) fq[k][i] = -sc;
      sc = sc * 5;
    end
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 64; i++) sq[k][i] = 0;
    bitCount = 0; frameCount = 0; outCount = 0;
    held = 0; expValid = 0;
  endtask

  task automatic modelStep(input bit b);
    longint v;
    longint u;
    v = b ? 64'sd1 : -64'sd1;
    for (int k = 0; k < 4; k++) begin
      for (int i = 4; i > 0; i--) fq[k][i] = fq[k][i-1];
      fq[k][0] = v;
      v = 0;
      for (int i = 0; i < 5; i++) v = v + fq[k][i];
    end
    bitCount++;
    expValid = 0;
    if (bitCount % 5 == 0) begin
      u = v;
      for (int k = 0; k < 4; k++) begin
        for (int i = 63; i > 0; i--) sq[k][i] = sq[k][i-1];
        sq[k][0] = u;
        u = 0;
        for (int i = 0; i < 64; i++) u = u + sq[k][i];
      end
      frameCount++;
      if (frameCount % 64 == 0) begin
        expValid = 1;
        held = u;
        outCount++;
      end
    end
  endtask

  task automatic stepBit(input bit b);
    longint mag;
    bitIn = b;
    @(posedge clk);
    modelStep(b);
    @(negedge clk);
    chk("R2", longint'(outValid), longint'(expValid));
    if (expValid) begin
      if (outCount == 1) chk("R5", longint'(dataOut), held);
      else               chk("R1", longint'(dataOut), held);
      mag = longint'(dataOut);
      if (mag < 0) mag = -mag;
      chk("R7", (mag <= FULLSCALE) ? 1 : 0, 1);
    end else begin
      chk("R3", longint'(dataOut), held);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", longint'(outValid), 0);
    chk("R6", longint'(dataOut), 0);
    rst = 1'b0;
    modelReset();
  endtask

  function automatic bit nextBit(input int mode, input int n);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return n[0];
      3: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
      end
      default: return (n % 3 == 0);
    endcase
  endfunction

  initial begin
    int mode;
    int nOut;
    applyReset();
    for (int p = 0; p < 6; p++) begin
      mode = int'(PLAN[p][27:24]);
      lfsr = PLAN[p][23:8];
      nOut = int'(PLAN[p][7:0]);
      applyReset();
      for (int n = 0; n < nOut * 320; n++) stepBit(nextBit(mode, n));
      if (mode == 0) chk("R4", longint'(dataOut), FULLSCALE);
      if (mode == 1) chk("R4", longint'(dataOut), -FULLSCALE);
    end
    // mid-stream reset: phase must restart from the release (R6)
    applyReset();
    for (int n = 0; n < 150; n++) stepBit(1'b1);
    applyReset();
    lfsr = 16'h5A5A;
    for (int n = 0; n < 2 * 320; n++) stepBit(nextBit(3, n));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule